// File: doc/BRIEF.md
# UART Receive Line Status with Queued Error Tags

This block keeps the receive-side status byte of a 16550-class serial port. A deserializer hands it each finished character together with the parity bit it received. The block judges that parity against the selected sense and stores the character, so the CPU can later read the status byte and the data. The same storage serves two modes. In single-holding mode the block behaves like one buffer register, and a late read loses data through overwrite. In queued mode up to `DEPTH` characters wait in order, each with its own parity-error tag.

Data-available, overrun and parity-error flags are derived from that storage and from two sticky registers. In queued mode the parity-error flag describes only the character currently at the head of the queue, so software learns which byte was damaged. When the mode input changes, the stored characters are thrown away. Framing, break and transmitter bits read as zero.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status byte reads 0x00 and no character is held.
- R2: Status bit 0 (data available) is 1 from the cycle after a character is stored until the last stored character has been read through `rbr_rd`; it is 0 otherwise.
- R3: In queued mode (`fifo_mode`=1) up to `DEPTH` (default 16) characters are held, and `rbr_data` presents them in arrival order, one per `rbr_rd` pulse.
- R4: In queued mode, a character that arrives while the queue is full and no read is made in the same cycle sets status bit 1 (overrun) and is discarded; the queued characters stay unchanged.
- R5: In holding mode (`fifo_mode`=0), a character that arrives while an unread character is held and no read is made in that cycle sets status bit 1 and replaces the held character.
- R6: Status bit 1 clears on the cycle after an `lsr_rd` pulse, unless a new overrun occurs in the same cycle as the read, in which case it stays 1.
- R7: A character fails its parity check when `even_par_sel`=1 and the count of ones in its data bits plus its parity bit is odd, or when `even_par_sel`=0 and that count is even.
- R8: In holding mode, status bit 2 (parity error) is set by a failing character and stays set, even after the data is read, until an `lsr_rd` pulse; a failing character arriving in the same cycle as the read keeps it set.
- R9: In queued mode, status bit 2 equals the parity tag of the character at the head of the queue and follows each new head after a read; an `lsr_rd` pulse hides the current head's tag until the next read.
- R10: A full queue that receives a character in the same cycle as a `rbr_rd` pulse stores it without overrun.
- R11: A change of `fifo_mode` empties the stored characters, so status bit 0 reads 0 on the following cycle; a character arriving in that cycle is dropped.
- R12: Status bits 7 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_mode | input | 1 | 1 selects queued mode, 0 selects holding mode |
| even_par_sel | input | 1 | 1 selects even parity, 0 selects odd parity |
| rx_valid | input | 1 | One-cycle strobe for a finished received character |
| rx_data | input | DATA_W | Data bits of the received character |
| rx_par_bit | input | 1 | Parity bit received with the character |
| rbr_rd | input | 1 | CPU read of the receive data; removes the head character |
| lsr_rd | input | 1 | CPU read of the status byte |
| lsr_out | output | 8 | Status byte: bit 0 data available, bit 1 overrun, bit 2 parity error |
| rbr_data | output | DATA_W | Character presented to the CPU (head of storage) |

## Verification
On every cycle the assertions check several properties. Any accepted strobe leaves data available on the next cycle. An overrun always shows in bit 1, and a status read with no new overrun clears it. Occupancy never exceeds the depth, and holding mode never holds more than one character. A mode change leaves storage empty. A failing character in holding mode raises the sticky parity flag. The upper bits stay zero. Only the bench scenarios show which character survives an overwrite or a full-queue drop, arrival order across a full drain, the head-by-head motion of the parity tag and its hiding after a status read, and the same-cycle read and arrival priorities.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
   // status byte width and the bit positions software decodes
   localparam int unsigned STAT_W  = 8;
   localparam int unsigned LSR_DR  = 0;
   localparam int unsigned LSR_OE  = 1;
   localparam int unsigned LSR_PE  = 2;

   typedef enum logic {
      MODE_HOLD  = 1'b0,
      MODE_QUEUE = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/rx_parity_judge.sv
module rx_parity_judge #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              even_sel,
   input  logic [DATA_W-1:0] data,
   input  logic              par_bit,
   output logic              par_err
);
   logic odd_ones;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("rx_parity_judge: DATA_W must be at least 1");
      end
   endgenerate

   // odd_ones is 1 when data plus parity carries an odd number of ones
   assign odd_ones = ^{data, par_bit};
   assign par_err  = even_sel ? odd_ones : ~odd_ones;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
   parameter int unsigned ENTRY_W = 9,
   parameter int unsigned DEPTH   = 16,
   localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W  = AW + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               push,
   input  logic               pop,
   input  logic               overwrite,
   input  logic [ENTRY_W-1:0] wdata,
   output logic [ENTRY_W-1:0] head,
   output logic               empty,
   output logic               full,
   output logic [CNT_W-1:0]   count
);
   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [AW-1:0]      wr_ptr, rd_ptr;
   logic [AW-1:0]      wr_nxt, rd_nxt;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_char_queue: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end else if (overwrite) begin
         mem[rd_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/lsr_flag_unit.sv
module lsr_flag_unit
   import uart_lsr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  rx_mode_e          mode,
   input  logic              ovr_evt,
   input  logic              bad_hold,
   input  logic              lsr_rd,
   input  logic              pop,
   input  logic              flush,
   input  logic              empty,
   input  logic              head_pe,
   output logic [STAT_W-1:0] lsr
);
   logic oe_q, pe_q, ack_q;
   logic pe_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q  <= 1'b0;
         pe_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         // a fresh event beats a same-cycle status read
         oe_q  <= ovr_evt  | (oe_q & ~lsr_rd);
         pe_q  <= bad_hold | (pe_q & ~lsr_rd);
         // a status read hides the head tag until the head moves
         ack_q <= ~pop & ~flush & (ack_q | (lsr_rd & ~empty));
      end
   end

   always_comb begin
      if (mode == MODE_QUEUE) pe_bit = ~empty & head_pe & ~ack_q;
      else                    pe_bit = pe_q;
   end

   always_comb begin
      lsr         = '0;
      lsr[LSR_DR] = ~empty;
      lsr[LSR_OE] = oe_q;
      lsr[LSR_PE] = pe_bit;
   end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_lsr_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned ENTRY_W = DATA_W + 1,
   localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W   = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode,
   input  logic              even_par_sel,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_par_bit,
   input  logic              rbr_rd,
   input  logic              lsr_rd,
   output logic [7:0]        lsr_out,
   output logic [DATA_W-1:0] rbr_data
);
   rx_mode_e           mode_q;
   logic               flush;
   logic               par_err;
   logic               rx_in, pop, push, overwrite, ovr_evt, bad_hold;
   logic               q_empty, q_full, occupied;
   logic [CNT_W-1:0]   q_count;
   logic [ENTRY_W-1:0] q_head;
   logic [STAT_W-1:0]  lsr_int;

   generate
      if (STAT_W != 8) begin : g_bad_stat
         $error("uart_rx_status: status byte must be 8 bits");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_HOLD;
      else        mode_q <= rx_mode_e'(fifo_mode);
   end

   assign flush    = (fifo_mode != mode_q);
   assign rx_in    = rx_valid & ~flush;
   assign pop      = rbr_rd & ~q_empty & ~flush;
   // holding mode treats a single stored character as full
   assign occupied = (mode_q == MODE_QUEUE) ? q_full : ~q_empty;
   assign ovr_evt  = rx_in & occupied & ~pop;
   assign overwrite = ovr_evt & (mode_q == MODE_HOLD);
   assign push     = rx_in & ~ovr_evt;
   assign bad_hold = rx_in & par_err & (mode_q == MODE_HOLD);

   rx_parity_judge #(.DATA_W(DATA_W)) u_judge (
      .even_sel (even_par_sel),
      .data     (rx_data),
      .par_bit  (rx_par_bit),
      .par_err  (par_err)
   );

   rx_char_queue #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (push),
      .pop       (pop),
      .overwrite (overwrite),
      .wdata     ({par_err, rx_data}),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full),
      .count     (q_count)
   );

   lsr_flag_unit u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_q),
      .ovr_evt  (ovr_evt),
      .bad_hold (bad_hold),
      .lsr_rd   (lsr_rd),
      .pop      (pop),
      .flush    (flush),
      .empty    (q_empty),
      .head_pe  (q_head[ENTRY_W-1]),
      .lsr      (lsr_int)
   );

   assign lsr_out  = lsr_int;
   assign rbr_data = q_head[DATA_W-1:0];
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_q,
   input logic             flush,
   input logic             ovr_evt,
   input logic             par_err,
   input logic             rx_valid,
   input logic             lsr_rd,
   input logic [CNT_W-1:0] q_count,
   input logic [7:0]       lsr_out
);
   p_dr_after_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !flush) |=> lsr_out[0]);

   p_oe_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_evt |=> lsr_out[1]);

   p_oe_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ovr_evt) |=> !lsr_out[1]);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_hold_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q |-> (q_count <= CNT_W'(1)));

   p_sticky_pe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && rx_valid && !flush && par_err) |=> lsr_out[2]);

   p_pe_needs_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !lsr_out[0]) |-> !lsr_out[2]);

   p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !lsr_out[0]);

   p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_out[7:3] == 5'd0);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_q   (mode_q),
   .flush    (flush),
   .ovr_evt  (ovr_evt),
   .par_err  (par_err),
   .rx_valid (rx_valid),
   .lsr_rd   (lsr_rd),
   .q_count  (q_count),
   .lsr_out  (lsr_out)
);

// File: tb/test_uart_rx_status.sv
`timescale 1ns/1ps
module test_uart_rx_status;
   localparam int DEPTH = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode = 1'b0;
   logic       even_par_sel = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_par_bit = 1'b0;
   logic       rbr_rd = 1'b0;
   logic       lsr_rd = 1'b0;
   logic [7:0] lsr_out;
   logic [7:0] rbr_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [8:0] sb [$];
   logic [8:0] got;

   always #4 clk = ~clk;

   uart_rx_status #(.DATA_W(8), .DEPTH(DEPTH)) i_uart_rx_status (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .even_par_sel(even_par_sel),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_bit(rx_par_bit),
      .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .lsr_out(lsr_out), .rbr_data(rbr_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // parity bit that passes (or, when corrupt, fails) the selected check
   function automatic logic pbit(input logic [7:0] d, input logic even, input logic corrupt);
      logic ok;
      ok = even ? ^d : ~^d;
      return ok ^ corrupt;
   endfunction

   // monitor: every read is compared against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rbr_rd) begin
         if (sb.size() == 0) begin
            check("R3 read with empty scoreboard", 32'(rbr_data), 32'hFFFF);
         end else begin
            got = sb.pop_front();
            check("R3 read order", 32'(rbr_data), 32'(got[7:0]));
         end
      end
   end

   task automatic drive(input logic v, input logic [7:0] d, input logic corrupt,
                        input logic rd, input logic lr);
      @(posedge clk); #1;
      rx_valid   = v;
      rx_data    = d;
      rx_par_bit = pbit(d, even_par_sel, corrupt);
      rbr_rd     = rd;
      lsr_rd     = lr;
   endtask

   // driver: apply one character and push the expectation when it is kept
   task automatic send(input logic [7:0] d, input logic corrupt, input logic keep,
                       input logic rd = 1'b0, input logic lr = 1'b0);
      drive(1'b1, d, corrupt, rd, lr);
      if (keep) sb.push_back({corrupt, d});
   endtask

   task automatic rd_data(input logic lr = 1'b0);
      drive(1'b0, 8'h00, 1'b0, 1'b1, lr);
   endtask

   task automatic rd_stat();
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic idle();
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic chk_lsr(input string req, input logic [7:0] exp);
      idle();
      @(negedge clk);
      check(req, 32'(lsr_out), 32'(exp));
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset status", 32'(lsr_out), 32'h00);

      // holding mode, even parity
      send(8'hA5, 1'b0, 1'b1);
      chk_lsr("R2 data available after store", 8'h01);
      rd_data();
      chk_lsr("R2 cleared after read", 8'h00);

      // R5: second char overwrites first
      send(8'h11, 1'b0, 1'b0);
      send(8'h22, 1'b0, 1'b1);
      chk_lsr("R5 overrun in holding mode", 8'h03);
      rd_stat();
      chk_lsr("R6 overrun cleared by status read", 8'h01);
      rd_data();
      chk_lsr("R5 holding register empty", 8'h00);

      // R7/R8: odd parity, sticky error
      even_par_sel = 1'b0;
      send(8'h3C, 1'b1, 1'b1);
      chk_lsr("R7 odd parity failure flagged", 8'h05);
      rd_data();
      chk_lsr("R8 error sticks after data read", 8'h04);
      rd_stat();
      chk_lsr("R8 error cleared by status read", 8'h00);
      send(8'h5A, 1'b1, 1'b1, 1'b0, 1'b1);
      chk_lsr("R8 new error wins over same-cycle read", 8'h05);
      rd_data(1'b1);
      chk_lsr("R8 cleared with data read", 8'h00);
      send(8'h0F, 1'b0, 1'b1);
      chk_lsr("R7 odd parity pass", 8'h01);
      rd_data();

      // R6: overrun and status read in the same cycle
      send(8'h44, 1'b0, 1'b0);
      send(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
      chk_lsr("R6 overrun wins over same-cycle read", 8'h03);
      rd_stat();
      chk_lsr("R6 overrun cleared", 8'h01);

      // R11: switch to queued mode with a character held
      @(posedge clk); #1 fifo_mode = 1'b1;
      chk_lsr("R11 mode change empties storage", 8'h00);

      // queued mode, even parity; tags on entries 3 and 5
      even_par_sel = 1'b1;
      for (int i = 0; i < DEPTH; i++) send(8'(8'h80 + i), (i == 3) || (i == 5), 1'b1);
      chk_lsr("R3 full queue no overrun", 8'h01);
      send(8'hEE, 1'b0, 1'b0);
      chk_lsr("R4 overrun on full queue", 8'h03);
      rd_stat();
      chk_lsr("R6 overrun cleared in queued mode", 8'h01);
      for (int i = 0; i < DEPTH; i++) begin
         if (i == 3) begin
            chk_lsr("R9 tag shown at head", 8'h05);
            rd_stat();
            chk_lsr("R9 tag hidden after status read", 8'h01);
         end else begin
            chk_lsr("R9 head tag", (i == 5) ? 8'h05 : 8'h01);
         end
         rd_data();
      end
      chk_lsr("R2 empty after drain, R4 dropped char absent", 8'h00);

      // R10: read and arrive together on a full queue
      for (int i = 0; i < DEPTH; i++) send(8'(8'h10 + i), 1'b0, 1'b1);
      send(8'h99, 1'b0, 1'b1, 1'b1, 1'b0);
      chk_lsr("R10 no overrun on read plus arrival", 8'h01);
      for (int i = 0; i < DEPTH; i++) rd_data();
      chk_lsr("R10 drained", 8'h00);

      // R7 in queued mode with odd parity
      even_par_sel = 1'b0;
      send(8'h07, 1'b0, 1'b1);
      send(8'h70, 1'b1, 1'b1);
      chk_lsr("R7 odd pass at head", 8'h01);
      rd_data();
      chk_lsr("R9 failing char reaches head", 8'h05);
      rd_data();
      chk_lsr("R12 upper bits zero at end", 8'h00);
      check("R3 scoreboard consumed", 32'(sb.size()), 32'd0);

      finish_run();
   end
endmodule